// File: doc/BRIEF.md
# Right-Hand Wall-Following Steering Controller

This block is the decision core of a small maze-walking robot. Two contact feelers, one on each side of the nose, report whether the robot is touching a wall. The block holds a short record of the situation the robot is in: searching for a wall, facing a wall, grazing the right wall, or having just lost the right wall. From that record it issues three motion commands: step forward, veer left and veer right. The policy keeps a wall on the robot's right-hand side until it finds the exit.

The commands are a pure function of the registered state, so they change only on a clock edge. They never depend directly on the feelers in the same cycle. Two builds are available through one parameter. The full build keeps "just lost the wall" and "clear of the wall" as separate states, which needs three state bits. The reduced build merges those two states, because they behave identically, and so needs only two state bits. Both builds give the same command sequence for any feeler sequence.

The feelers and commands are plain level signals with no handshake. A new feeler sample is taken on every rising clock edge.

Top module: `wall_follower`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the controller is in the searching state. In that state `step_fwd`=1, `turn_left`=0 and `turn_right`=0. An asynchronous reset during operation returns it to this state.
- R2: Commands per state, given as {step_fwd, turn_left, turn_right}: searching = 100, facing wall = 010, grazing wall = 110, clear of wall and wall break = 101. `turn_left` and `turn_right` are never both 1. `step_fwd` is 0 only while facing a wall.
- R3: From the searching state, if either feeler is 1 the next state is facing wall. If both feelers are 0 the controller stays in searching.
- R4: From facing wall, the controller stays there while either feeler is 1. When both feelers are 0 it moves to clear of wall.
- R5: From grazing wall, `sense_left`=1 moves to facing wall, whatever `sense_right` is. Otherwise `sense_right`=1 stays in grazing and `sense_right`=0 moves to clear of wall.
- R6: From clear of wall or wall break, `sense_right`=1 moves to grazing wall and `sense_right`=0 moves to (or stays in) wall break. `sense_left` has no effect in these states.
- R7: With `MERGED`=1 the commands are identical, cycle for cycle, to those of `MERGED`=0 for every feeler sequence and reset pattern.
- R8: The commands depend only on registered state. A feeler change between clock edges leaves the commands unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to the searching state |
| sense_left | input | 1 | Left feeler, 1 while touching a wall |
| sense_right | input | 1 | Right feeler, 1 while touching a wall |
| step_fwd | output | 1 | Step forward |
| turn_left | output | 1 | Veer slightly left |
| turn_right | output | 1 | Veer slightly right |

## Verification
The bench builds two copies side by side: one with `MERGED`=0 (three-bit state, separate break state) and one with `MERGED`=1 (two-bit state). Every cycle is checked on both, so any divergence between the merged and unmerged paths shows up at the ports. A directed vector walk visits every state and every transition arc, including left-feeler priority in the grazing state and a left feeler that is ignored after the wall is lost. A long pseudo-random feeler run is then compared against a behavioural model.

// File: rtl/wf_pkg.sv
`timescale 1ns/1ps
package wf_pkg;

  // Motion command bundle: forward, veer left, veer right
  typedef struct packed {
    logic fwd;
    logic tl;
    logic tr;
  } motion_t;

  // Full (three-bit) state codes
  localparam logic [2:0] F_SEEK  = 3'b000;
  localparam logic [2:0] F_FACE  = 3'b001;
  localparam logic [2:0] F_GRAZE = 3'b010;
  localparam logic [2:0] F_CLEAR = 3'b011;
  localparam logic [2:0] F_GAP   = 3'b100;

  // Reduced (two-bit) state codes: clear and gap share one code
  localparam logic [1:0] M_SEEK  = 2'b00;
  localparam logic [1:0] M_FACE  = 2'b01;
  localparam logic [1:0] M_GRAZE = 2'b10;
  localparam logic [1:0] M_CLEAR = 2'b11;

  localparam motion_t MV_SEEK  = '{fwd: 1'b1, tl: 1'b0, tr: 1'b0};
  localparam motion_t MV_FACE  = '{fwd: 1'b0, tl: 1'b1, tr: 1'b0};
  localparam motion_t MV_GRAZE = '{fwd: 1'b1, tl: 1'b1, tr: 1'b0};
  localparam motion_t MV_CLEAR = '{fwd: 1'b1, tl: 1'b0, tr: 1'b1};

endpackage

// File: rtl/wf_step_full.sv
`timescale 1ns/1ps
// Next-state logic for the five-state policy; spare codes fall back to searching.
module wf_step_full
  import wf_pkg::*;
(
  input  logic [2:0] cur,
  input  logic       feel_l,
  input  logic       feel_r,
  output logic [2:0] nxt
);
  always_comb begin
    unique case (cur)
      F_SEEK:  nxt = (feel_l | feel_r) ? F_FACE : F_SEEK;
      F_FACE:  nxt = (feel_l | feel_r) ? F_FACE : F_CLEAR;
      F_GRAZE: begin
        if (feel_l)      nxt = F_FACE;
        else if (feel_r) nxt = F_GRAZE;
        else             nxt = F_CLEAR;
      end
      F_CLEAR: nxt = feel_r ? F_GRAZE : F_GAP;
      F_GAP:   nxt = feel_r ? F_GRAZE : F_GAP;
      default: nxt = F_SEEK;
    endcase
  end
endmodule

// File: rtl/wf_step_merged.sv
`timescale 1ns/1ps
// Next-state logic for the four-state policy (clear and gap merged).
module wf_step_merged
  import wf_pkg::*;
(
  input  logic [1:0] cur,
  input  logic       feel_l,
  input  logic       feel_r,
  output logic [1:0] nxt
);
  always_comb begin
    unique case (cur)
      M_SEEK:  nxt = (feel_l | feel_r) ? M_FACE : M_SEEK;
      M_FACE:  nxt = (feel_l | feel_r) ? M_FACE : M_CLEAR;
      M_GRAZE: begin
        if (feel_l)      nxt = M_FACE;
        else if (feel_r) nxt = M_GRAZE;
        else             nxt = M_CLEAR;
      end
      default: nxt = feel_r ? M_GRAZE : M_CLEAR;
    endcase
  end
endmodule

// File: rtl/wf_motion.sv
`timescale 1ns/1ps
// Moore output decode; the variant is chosen by MERGED.
module wf_motion
  import wf_pkg::*;
#(
  parameter bit MERGED = 1'b0,
  localparam int W = MERGED ? 2 : 3
)(
  input  logic [W-1:0] code,
  output motion_t      mv
);
  generate
    if (MERGED) begin : g_merged
      always_comb begin
        unique case (code)
          M_SEEK:  mv = MV_SEEK;
          M_FACE:  mv = MV_FACE;
          M_GRAZE: mv = MV_GRAZE;
          default: mv = MV_CLEAR;
        endcase
      end
    end else begin : g_full
      always_comb begin
        unique case (code)
          F_SEEK:           mv = MV_SEEK;
          F_FACE:           mv = MV_FACE;
          F_GRAZE:          mv = MV_GRAZE;
          F_CLEAR, F_GAP:   mv = MV_CLEAR;
          default:          mv = MV_SEEK;   // spare codes: forward only
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/wf_state_reg.sv
`timescale 1ns/1ps
module wf_state_reg #(
  parameter int W = 3,
  parameter logic [W-1:0] RESET_CODE = '0
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_CODE;
    else        q <= d;
  end
endmodule

// File: rtl/wall_follower.sv
`timescale 1ns/1ps
module wall_follower
  import wf_pkg::*;
#(
  parameter bit MERGED = 1'b0
)(
  input  logic clk,
  input  logic rst_n,
  input  logic sense_left,
  input  logic sense_right,
  output logic step_fwd,
  output logic turn_left,
  output logic turn_right
);
  localparam int SW = MERGED ? 2 : 3;

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  motion_t       mv;

  generate
    if (MERGED) begin : g_step
      wf_step_merged u_step (
        .cur    (state_q),
        .feel_l (sense_left),
        .feel_r (sense_right),
        .nxt    (state_d)
      );
    end else begin : g_step
      wf_step_full u_step (
        .cur    (state_q),
        .feel_l (sense_left),
        .feel_r (sense_right),
        .nxt    (state_d)
      );
    end
  endgenerate

  wf_state_reg #(.W(SW), .RESET_CODE('0)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (state_d),
    .q     (state_q)
  );

  wf_motion #(.MERGED(MERGED)) u_motion (
    .code (state_q),
    .mv   (mv)
  );

  assign step_fwd   = mv.fwd;
  assign turn_left  = mv.tl;
  assign turn_right = mv.tr;

  // R2: never veer both ways at once
  a_r2_veer_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(turn_left && turn_right));

  // R2: forward is dropped only while facing a wall
  a_r2_halt_only_facing: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fwd |-> (turn_left && !turn_right));

  // R3: searching plus any contact leads to facing wall
  a_r3_seek_to_face: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fwd && !turn_left && !turn_right && (sense_left || sense_right))
      |=> (!step_fwd && turn_left));

  // R4: facing wall persists while contact persists
  a_r4_face_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fwd && (sense_left || sense_right)) |=> !step_fwd);

  // R5: left contact while grazing wins over the right feeler
  a_r5_graze_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fwd && turn_left && sense_left) |=> (!step_fwd && turn_left));

  // R6: right contact after losing the wall resumes grazing, left ignored
  a_r6_regain_wall: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_right && sense_right) |=> (step_fwd && turn_left && !turn_right));

  // R6: no right contact after losing the wall keeps veering right
  a_r6_keep_seeking_right: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_right && !sense_right) |=> (step_fwd && turn_right));

endmodule

// File: tb/tb_wall_follower.sv
`timescale 1ns/1ps
module tb_wall_follower;

  logic clk = 1'b0;
  logic rst_n;
  logic sl, sr;
  logic f0, l0, r0;
  logic f1, l1, r1;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  wall_follower #(.MERGED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .sense_left(sl), .sense_right(sr),
    .step_fwd(f0), .turn_left(l0), .turn_right(r0));

  wall_follower #(.MERGED(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .sense_left(sl), .sense_right(sr),
    .step_fwd(f1), .turn_left(l1), .turn_right(r1));

  // {req[3:0], left, right, exp fwd, exp tl, exp tr}, starting from searching
  localparam int NV = 16;
  localparam logic [8:0] VEC [NV] = '{
    {4'd3, 2'b00, 3'b100},  // R3 stay searching
    {4'd3, 2'b01, 3'b010},  // R3 right contact -> facing
    {4'd4, 2'b10, 3'b010},  // R4 hold facing
    {4'd4, 2'b00, 3'b101},  // R4 -> clear
    {4'd6, 2'b10, 3'b101},  // R6 left ignored -> gap
    {4'd6, 2'b10, 3'b101},  // R6 gap holds
    {4'd6, 2'b01, 3'b110},  // R6 -> grazing
    {4'd5, 2'b01, 3'b110},  // R5 grazing holds
    {4'd5, 2'b11, 3'b010},  // R5 left wins -> facing
    {4'd4, 2'b11, 3'b010},  // R4 hold facing
    {4'd4, 2'b00, 3'b101},  // R4 -> clear
    {4'd6, 2'b11, 3'b110},  // R6 clear -> grazing, left ignored
    {4'd5, 2'b00, 3'b101},  // R5 grazing -> clear
    {4'd6, 2'b00, 3'b101},  // R6 clear -> gap
    {4'd6, 2'b11, 3'b110},  // R6 gap -> grazing
    {4'd5, 2'b10, 3'b010}   // R5 left contact -> facing
  };

  task automatic check(input int req, input logic [2:0] got, input logic [2:0] exp,
                       input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic check_both(input int req, input logic [2:0] exp, input string what);
    check(req, {f0, l0, r0}, exp, {what, " full"});
    check(7,   {f1, l1, r1}, exp, {what, " merged (R7)"});
  endtask

  // Behavioural reference: 0 seek, 1 face, 2 graze, 3 clear/gap
  function automatic int ref_next(input int s, input logic l, input logic r);
    case (s)
      0: return (l || r) ? 1 : 0;
      1: return (l || r) ? 1 : 3;
      2: return l ? 1 : (r ? 2 : 3);
      default: return r ? 2 : 3;
    endcase
  endfunction

  function automatic logic [2:0] ref_out(input int s);
    case (s)
      0: return 3'b100;
      1: return 3'b010;
      2: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int ms;
    rst_n = 1'b0; sl = 1'b0; sr = 1'b0;
    repeat (3) @(posedge clk);
    #1 check_both(1, 3'b100, "in reset");              // R1
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check_both(1, 3'b100, "after release");         // R1

    // Directed vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk) {sl, sr} = VEC[i][4:3];
      @(posedge clk);
      #1 check_both(int'(VEC[i][8:5]), VEC[i][2:0], $sformatf("vector %0d", i));
    end

    // R1: reset during operation
    @(negedge clk) begin rst_n = 1'b0; sl = 1'b0; sr = 1'b0; end
    @(posedge clk);
    #1 check_both(1, 3'b100, "mid-run reset");
    @(negedge clk) rst_n = 1'b1;

    // R3: left contact alone from searching
    @(negedge clk) begin sl = 1'b1; sr = 1'b0; end
    @(posedge clk);
    #1 check_both(3, 3'b010, "left-only from searching");

    // R8: feeler change between edges has no immediate effect
    sl = 1'b0; sr = 1'b0;
    #0.5 check_both(8, 3'b010, "between edges");
    @(posedge clk);
    #1 check_both(4, 3'b101, "facing released");

    // R7: long random run against reference, both builds
    ms = 3;
    for (int k = 0; k < 3000; k++) begin
      logic nl, nr;
      @(negedge clk);
      nl = 1'($urandom_range(0, 1));
      nr = 1'($urandom_range(0, 1));
      sl = nl; sr = nr;
      ms = ref_next(ms, nl, nr);
      @(posedge clk);
      #1 check_both(7, ref_out(ms), "random run");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule